// File: doc/BRIEF.md
# Asynchronous Byte-Wide EPROM Read Sequencer

This block sits on the host side of an asynchronous, byte-wide ultraviolet-erasable or one-time-programmable memory with an 18-bit address and 8-bit data. It accepts one read at a time on a valid/ready request port. For each accepted read it drives the address, pulls the active-low select line low, and lowers the active-low output gate at the right moment. It captures the byte on a fixed clock edge and returns it with a single-cycle valid strobe.

The select line is used as the power and select control, and the output gate is used only to put the byte on the bus. Reads that follow each other closely keep the device selected and change only the address. When no request arrives for a programmable number of cycles, the select line is raised and the device drops into its low-power standby state. Every analogue delay is given as a whole number of system clock cycles, rounded up from the grade in use. The delays are: address or select to data, gate to data, and the time the data pins take to float after the gate is released.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held and after its release, before any request, memCeN = 1, memOeN = 1, rdValid = 0, reqReady = 1 and memAddr = 0.
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. From the next cycle, memAddr shows the taken address, memCeN is 0 and reqReady is 0.
- R3: With S = max(T_ACC, T_OE), memOeN goes low OES = S - T_OE cycles after the edge that takes the request and stays low until the sampling edge.
- R4: The byte on memData is captured at the edge S cycles after the edge that takes the request. rdData holds that byte and rdValid is 1 for exactly the one following cycle, with memOeN back at 1 in that cycle.
- R5: memOeN is never 0 while memCeN is 1.
- R6: memAddr changes only on an edge that takes a request, so it is stable from acceptance through sampling.
- R7: reqReady returns to 1 S + T_FLOAT cycles after the edge that took the previous request. This gives the data pins T_FLOAT cycles to float after the gate rises.
- R8: When the next request is taken before the idle timeout, memCeN stays 0 across the two reads.
- R9: If no request is taken for IDLE_TO cycles after reqReady returns, memCeN goes to 1 (standby), which is S + T_FLOAT + IDLE_TO cycles after the last accepted request.
- R10: A request taken on the same edge at which the idle timeout would expire wins, and memCeN stays 0.
- R11: reqValid and reqAddr are ignored while reqReady is 0. memAddr does not follow address changes offered during a busy access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Sequencer can take a request |
| reqAddr | input | ADDR_W | Byte address of the request |
| rdValid | output | 1 | One-cycle strobe: rdData holds a fresh byte |
| rdData | output | DATA_W | Captured byte |
| memAddr | output | ADDR_W | Address bus to the memory |
| memCeN | output | 1 | Active-low select / power line |
| memOeN | output | 1 | Active-low output gate |
| memData | input | DATA_W | Data pins of the memory |

## Verification
Every result is timed from the edge that takes a request:
- memCeN and memAddr change in the very next cycle.
- memOeN falls OES cycles later and rises at the sampling edge S.
- rdValid appears in the cycle after edge S.
- reqReady returns at S + T_FLOAT.
- Standby starts at S + T_FLOAT + IDLE_TO unless another request has been taken.

The bench keeps the cycle index of the last accepted request. At each falling clock edge it derives every expected port value from the distance to that index, so each result is compared in exactly the cycle it is due. A behavioural memory in the bench returns the complement of the correct byte unless the address, select and gate have each been held long enough by the coming edge. A capture that comes one cycle early therefore shows up as wrong data.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  // Strobes sent from the sequencing control to the datapath.
  typedef struct packed {
    logic loadAddr;   // latch the request address onto the bus
    logic capture;    // sample the data pins, raise the valid strobe
    logic oeOn;       // pull the output gate low
    logic oeOff;      // release the output gate
    logic ceOn;       // select the device (leave standby)
    logic ceOff;      // deselect the device (enter standby)
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/eprom_rd_ctrl_fsm.sv
module eprom_rd_ctrl_fsm
  import eprom_rd_pkg::*;
#(
  parameter int T_ACC   = 11,
  parameter int T_OE    = 6,
  parameter int T_FLOAT = 6,
  parameter int IDLE_TO = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int SAMPLE_AT = (T_ACC > T_OE) ? T_ACC : T_OE;
  localparam int OE_START  = SAMPLE_AT - T_OE;
  localparam int MAX_CNT   = (SAMPLE_AT > IDLE_TO)
                             ? ((SAMPLE_AT > T_FLOAT) ? SAMPLE_AT : T_FLOAT)
                             : ((IDLE_TO > T_FLOAT) ? IDLE_TO : T_FLOAT);
  localparam int CNT_W     = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_AT - 1);
  localparam logic [CNT_W-1:0] OE_LAST     = CNT_W'((OE_START > 0) ? OE_START - 1 : 0);
  localparam logic [CNT_W-1:0] FLOAT_LAST  = CNT_W'(T_FLOAT - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST   = CNT_W'(IDLE_TO - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             asleep;
  logic             accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          stb.loadAddr = 1'b1;
          stb.ceOn     = 1'b1;
          stb.oeOn     = (OE_START == 0);
        end else if (!asleep && cnt == IDLE_LAST) begin
          stb.ceOff = 1'b1;
        end
      end
      ST_ACCESS: begin
        if (cnt == SAMPLE_LAST) begin
          stb.capture = 1'b1;
          stb.oeOff   = 1'b1;
        end else if (OE_START > 0 && cnt == OE_LAST) begin
          stb.oeOn = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      asleep <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_ACCESS;
            cnt    <= '0;
            asleep <= 1'b0;
          end else if (!asleep) begin
            if (cnt == IDLE_LAST) asleep <= 1'b1;
            else                  cnt    <= cnt + 1'b1;
          end
        end
        ST_ACCESS: begin
          if (cnt == SAMPLE_LAST) begin
            state <= ST_FLOAT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FLOAT: begin
          if (cnt == FLOAT_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/eprom_rd_datapath.sv
module eprom_rd_datapath
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memCeN  <= 1'b1;
      memOeN  <= 1'b1;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.capture;
      if (stb.loadAddr) memAddr <= reqAddr;
      if (stb.capture)  rdData  <= memData;
      if (stb.ceOn)       memCeN <= 1'b0;
      else if (stb.ceOff) memCeN <= 1'b1;
      if (stb.oeOn)       memOeN <= 1'b0;
      else if (stb.oeOff) memOeN <= 1'b1;
    end
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int T_ACC   = 11,
  parameter int T_OE    = 6,
  parameter int T_FLOAT = 6,
  parameter int IDLE_TO = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);

  strobe_t stb;

  eprom_rd_ctrl_fsm #(
    .T_ACC  (T_ACC),
    .T_OE   (T_OE),
    .T_FLOAT(T_FLOAT),
    .IDLE_TO(IDLE_TO)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .stb     (stb)
  );

  eprom_rd_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .reqAddr(reqAddr),
    .memData(memData),
    .memAddr(memAddr),
    .memCeN (memCeN),
    .memOeN (memOeN),
    .rdData (rdData),
    .rdValid(rdValid)
  );

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              rdValid
);

  p_accept_selects_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!memCeN && !reqReady));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  p_gate_released_at_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (memOeN && $past(!memOeN)));

  p_gate_needs_select_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN);

  p_addr_only_on_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> $stable(memAddr));

  p_busy_while_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !reqReady);

  p_standby_only_when_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (reqReady && memOeN));

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memOeN  (memOeN),
  .rdValid (rdValid)
);

// File: tb/eprom_rd_ctrl_bench.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_bench;

  localparam int ADDR_W  = 18;
  localparam int DATA_W  = 8;
  localparam int T_ACC   = 11;
  localparam int T_OE    = 6;
  localparam int T_FLOAT = 6;
  localparam int IDLE_TO = 16;
  localparam int S   = (T_ACC > T_OE) ? T_ACC : T_OE;
  localparam int OES = S - T_OE;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] memAddr;
  logic              memCeN;
  logic              memOeN;
  logic [DATA_W-1:0] memData = '0;

  always #2.5 clk = ~clk;

  eprom_rd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ACC(T_ACC),
    .T_OE(T_OE), .T_FLOAT(T_FLOAT), .IDLE_TO(IDLE_TO)
  ) u_eprom_rd_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memData(memData)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int lastAcc = -1;
  logic [ADDR_W-1:0] lastAddr = '0;
  logic [ADDR_W-1:0] pendAddr = '0;
  logic              pend = 1'b0;
  string             phase = "R1";

  // behavioural memory state
  int addrAge = 1000;
  int oeAge   = -1;
  int ceAge   = -1;
  logic [ADDR_W-1:0] prevAddr = '0;

  function automatic logic [DATA_W-1:0] memFn(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[17:10] ^ {a[9:8], 6'h0} ^ 8'h3C;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s (phase %s) %s cycle %0d: actual %0h expected %0h",
               req, phase, what, cyc, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [ADDR_W-1:0] a);
    int r;
    logic eCe, eOe, eRdy, eVal;
    logic [ADDR_W-1:0] eAddr;
    logic ok;
    @(negedge clk);
    cyc++;
    if (pend) begin
      lastAcc  = cyc;
      lastAddr = pendAddr;
    end
    r = (lastAcc >= 0) ? cyc - lastAcc : -1;
    if (r < 0) begin
      eCe = 1'b1; eOe = 1'b1; eRdy = 1'b1; eVal = 1'b0; eAddr = '0;
    end else begin
      eCe   = (r >= S + T_FLOAT + IDLE_TO);
      eOe   = !(r >= OES && r < S);
      eRdy  = (r >= S + T_FLOAT);
      eVal  = (r == S);
      eAddr = lastAddr;
    end
    check("R9", "memCeN", int'(memCeN), int'(eCe));
    check("R3", "memOeN", int'(memOeN), int'(eOe));
    check("R7", "reqReady", int'(reqReady), int'(eRdy));
    check("R4", "rdValid", int'(rdValid), int'(eVal));
    check("R6", "memAddr", int'(memAddr), int'(eAddr));
    if (eVal) check("R4", "rdData", int'(rdData), int'(memFn(lastAddr)));
    if (!memOeN) check("R5", "memCeN with gate low", int'(memCeN), 0);

    // memory model: drive correct byte only when every window is met at next edge
    addrAge = (memAddr != prevAddr) ? 0 : addrAge + 1;
    prevAddr = memAddr;
    oeAge = memOeN ? -1 : ((oeAge < 0) ? 0 : oeAge + 1);
    ceAge = memCeN ? -1 : ((ceAge < 0) ? 0 : ceAge + 1);
    ok = !memCeN && !memOeN && (addrAge + 1 >= T_ACC) &&
         (ceAge + 1 >= T_ACC) && (oeAge + 1 >= T_OE);
    memData = ok ? memFn(memAddr) : ~memFn(memAddr);

    reqValid = v;
    reqAddr  = a;
    pend     = v && eRdy;
    pendAddr = a;
  endtask

  initial begin
    // R1: reset values while reset is held
    repeat (3) @(negedge clk);
    check("R1", "memCeN in reset", int'(memCeN), 1);
    check("R1", "memOeN in reset", int'(memOeN), 1);
    check("R1", "rdValid in reset", int'(rdValid), 0);
    check("R1", "reqReady in reset", int'(reqReady), 1);
    rstN = 1'b1;
    repeat (3) step(1'b0, '0);

    // R2: single read from standby, then let it time out (R3 R4 R6 R7 R9)
    phase = "R2";
    step(1'b1, 18'h2A5C3);
    repeat (S + T_FLOAT + IDLE_TO + 4) step(1'b0, '0);

    // R8 / R11: request held high with a changing address
    phase = "R8";
    for (int i = 0; i < 4 * (S + T_FLOAT + 1); i++)
      step(1'b1, 18'(18'h01000 + i * 18'h00137));
    phase = "R11";
    repeat (S + T_FLOAT + IDLE_TO + 3) step(1'b0, '0);

    // R10: request lands on the timeout edge
    phase = "R10";
    step(1'b1, 18'h3FFFF);
    repeat (S + T_FLOAT + IDLE_TO - 1) step(1'b0, '0);
    step(1'b1, 18'h00001);
    repeat (S + T_FLOAT + IDLE_TO + 3) step(1'b0, '0);

    // R9: one cycle later than the timeout, device is in standby again
    phase = "R9";
    step(1'b1, 18'h15555);
    repeat (S + T_FLOAT + IDLE_TO - 1) step(1'b0, '0);
    step(1'b0, '0);
    step(1'b1, 18'h0ABCD);
    repeat (S + T_FLOAT + IDLE_TO + 3) step(1'b0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired at cycle %0d (phase %s)", cyc, phase);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule